// File: doc/BRIEF.md
# Posted Write Buffer with Read Fence

This block sits between a processor's memory-mapped I/O request port and a downstream network port. The processor can post a write, and the write counts as done at the processor side as soon as it is stored in a small ordered buffer. The block then sends the buffered writes downstream one at a time, oldest first. A write leaves the buffer only when the downstream side acknowledges it. If the downstream side refuses a write, the same write is sent again.

A read from the processor acts as a fence. It waits until every write posted before it has been acknowledged downstream. Only then is it forwarded, and its data is returned to the processor. The block also has a local status register at one fixed address. It reports how many posted writes are still unacknowledged, so software can poll it until it reads zero. Reading it never waits behind buffered writes.

Top module: `pwb_bridge`

## Requirements
- R1: A processor write is accepted (`cpu_req_ready` high) in the cycle it is presented, whenever the buffer holds fewer than DEPTH writes and no read is pending.
- R2: While the buffer holds DEPTH writes, a processor write is not accepted until an acknowledgement frees an entry.
- R3: A downstream request keeps `dn_req_valid` high, with address, data and direction unchanged, until `dn_req_ready` is sampled high.
- R4: After `dn_wr_nack`, the next downstream write carries the same address and data as the refused write. At most one downstream request is awaiting a response at any time.
- R5: Writes are acknowledged downstream in the order the processor posted them.
- R6: A read (`dn_req_write` low) is presented downstream only when the outstanding-write count is zero.
- R7: In the cycle after `dn_rd_valid`, the block pulses `cpu_rsp_valid` for one cycle with `cpu_rsp_rdata` equal to `dn_rd_data`.
- R8: A processor read at STATUS_ADDR is answered in the next cycle with the outstanding-write count, zero-extended. It is never forwarded downstream and does not wait for buffered writes.
- R9: The outstanding count rises by one for each accepted write and falls by one for each `dn_wr_ack`. It stays unchanged when both happen in the same cycle, and it always equals the buffer occupancy.
- R10: While a forwarded read is pending, no processor request is accepted.
- R11: Reset empties the buffer, zeroes the count, drops any pending read and leaves `dn_req_valid` low. Writes buffered before reset are never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Processor request accepted this cycle |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | AW | Request address; STATUS_ADDR selects the local status register |
| cpu_req_wdata | input | DW | Write data |
| cpu_rsp_valid | output | 1 | One-cycle read response pulse |
| cpu_rsp_rdata | output | DW | Read response data |
| dn_req_valid | output | 1 | Downstream request present |
| dn_req_ready | input | 1 | Downstream request taken |
| dn_req_write | output | 1 | 1 = write, 0 = read |
| dn_req_addr | output | AW | Downstream address |
| dn_req_wdata | output | DW | Downstream write data |
| dn_wr_ack | input | 1 | Write in flight accepted downstream |
| dn_wr_nack | input | 1 | Write in flight refused; resend |
| dn_rd_valid | input | 1 | Read response from downstream |
| dn_rd_data | input | DW | Read response data from downstream |

## Verification
The checks assume that the downstream side behaves well. It raises `dn_wr_ack` or `dn_wr_nack` only for a write that has been taken and is still waiting for its response, never both at once. It raises `dn_rd_valid` only for a read that has been taken. The bench's downstream model follows this rule. It records each request it takes, answers it one cycle later, and holds `dn_req_ready` low while a response is still owed. Processor requests are driven with the valid-until-ready discipline, and any write presented while a read is pending is withdrawn before it can be taken.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {
    DS_IDLE = 2'd0,
    DS_WACK = 2'd1,
    DS_RACK = 2'd2
  } ds_state_e;

endpackage

// File: rtl/pwb_rst_sync.sv
module pwb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/pwb_fifo.sv
module pwb_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          full,
  output logic          empty,
  output logic [LW-1:0] level
);

  logic [W-1:0]  mem [DEPTH];
  logic [LW-1:0] wr_ptr_q, wr_ptr_d;
  logic [LW-1:0] rd_ptr_q, rd_ptr_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (push) wr_ptr_d = wr_ptr_q + LW'(1);
    if (pop)  rd_ptr_d = rd_ptr_q + LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (push && (wr_ptr_q[PW-1:0] == PW'(g))) mem[g] <= push_data;
      end
    end
  endgenerate

  assign level = wr_ptr_q - rd_ptr_q;
  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);
  assign head  = mem[rd_ptr_q[PW-1:0]];

endmodule

// File: rtl/pwb_out_cnt.sv
module pwb_out_cnt #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    unique case ({inc, dec})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (inc != dec)  cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/pwb_dn_ctrl.sv
module pwb_dn_ctrl
  import pwb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_empty,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  input  logic          rd_pend,
  input  logic [AW-1:0] rd_addr,
  output logic          dn_req_valid,
  input  logic          dn_req_ready,
  output logic          dn_req_write,
  output logic [AW-1:0] dn_req_addr,
  output logic [DW-1:0] dn_req_wdata,
  input  logic          dn_wr_ack,
  input  logic          dn_wr_nack,
  input  logic          dn_rd_valid,
  output logic          pop,
  output logic          rd_done
);

  ds_state_e st_q, st_d;

  always_comb begin
    st_d         = st_q;
    dn_req_valid = 1'b0;
    dn_req_write = 1'b0;
    dn_req_addr  = '0;
    dn_req_wdata = '0;
    pop          = 1'b0;
    rd_done      = 1'b0;
    unique case (st_q)
      DS_IDLE: begin
        if (!buf_empty) begin
          dn_req_valid = 1'b1;
          dn_req_write = 1'b1;
          dn_req_addr  = head_addr;
          dn_req_wdata = head_data;
          if (dn_req_ready) st_d = DS_WACK;
        end else if (rd_pend) begin
          dn_req_valid = 1'b1;
          dn_req_addr  = rd_addr;
          if (dn_req_ready) st_d = DS_RACK;
        end
      end
      DS_WACK: begin
        if (dn_wr_ack) begin
          pop  = 1'b1;
          st_d = DS_IDLE;
        end else if (dn_wr_nack) begin
          st_d = DS_IDLE;
        end
      end
      DS_RACK: begin
        if (dn_rd_valid) begin
          rd_done = 1'b1;
          st_d    = DS_IDLE;
        end
      end
      default: st_d = DS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= DS_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/pwb_bridge.sv
module pwb_bridge #(
  parameter int          AW          = 32,
  parameter int          DW          = 32,
  parameter int          DEPTH       = 8,
  parameter logic [31:0] STATUS_ADDR = 32'hFFFF_FFF0,
  localparam int         CNT_W       = $clog2(DEPTH + 1),
  localparam int         EW          = AW + DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req_valid,
  output logic          cpu_req_ready,
  input  logic          cpu_req_write,
  input  logic [AW-1:0] cpu_req_addr,
  input  logic [DW-1:0] cpu_req_wdata,
  output logic          cpu_rsp_valid,
  output logic [DW-1:0] cpu_rsp_rdata,
  output logic          dn_req_valid,
  input  logic          dn_req_ready,
  output logic          dn_req_write,
  output logic [AW-1:0] dn_req_addr,
  output logic [DW-1:0] dn_req_wdata,
  input  logic          dn_wr_ack,
  input  logic          dn_wr_nack,
  input  logic          dn_rd_valid,
  input  logic [DW-1:0] dn_rd_data
);

  logic             rst_sn;
  logic             buf_full, buf_empty, buf_pop;
  logic [EW-1:0]    buf_head;
  logic [CNT_W-1:0] buf_level;
  logic [CNT_W-1:0] cnt_q;
  logic             rd_done;
  logic             is_status, acc, wr_acc, st_acc, rd_acc;
  logic             rd_pend_q, rd_pend_d;
  logic [AW-1:0]    rd_addr_q;
  logic             rsp_valid_q, rsp_valid_d;
  logic [DW-1:0]    rsp_data_q, rsp_data_d;

  pwb_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign is_status     = (cpu_req_addr == AW'(STATUS_ADDR));
  assign cpu_req_ready = !rd_pend_q && (!cpu_req_write || !buf_full);
  assign acc           = cpu_req_valid && cpu_req_ready;
  assign wr_acc        = acc && cpu_req_write;
  assign st_acc        = acc && !cpu_req_write && is_status;
  assign rd_acc        = acc && !cpu_req_write && !is_status;

  pwb_fifo #(.W(EW), .DEPTH(DEPTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_sn),
    .push      (wr_acc),
    .push_data ({cpu_req_addr, cpu_req_wdata}),
    .pop       (buf_pop),
    .head      (buf_head),
    .full      (buf_full),
    .empty     (buf_empty),
    .level     (buf_level)
  );

  pwb_out_cnt #(.DEPTH(DEPTH)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sn),
    .inc   (wr_acc),
    .dec   (buf_pop),
    .cnt   (cnt_q)
  );

  pwb_dn_ctrl #(.AW(AW), .DW(DW)) u_dn (
    .clk          (clk),
    .rst_n        (rst_sn),
    .buf_empty    (buf_empty),
    .head_addr    (buf_head[EW-1:DW]),
    .head_data    (buf_head[DW-1:0]),
    .rd_pend      (rd_pend_q),
    .rd_addr      (rd_addr_q),
    .dn_req_valid (dn_req_valid),
    .dn_req_ready (dn_req_ready),
    .dn_req_write (dn_req_write),
    .dn_req_addr  (dn_req_addr),
    .dn_req_wdata (dn_req_wdata),
    .dn_wr_ack    (dn_wr_ack),
    .dn_wr_nack   (dn_wr_nack),
    .dn_rd_valid  (dn_rd_valid),
    .pop          (buf_pop),
    .rd_done      (rd_done)
  );

  always_comb begin
    rd_pend_d = rd_pend_q;
    if (rd_acc)  rd_pend_d = 1'b1;
    if (rd_done) rd_pend_d = 1'b0;
    rsp_valid_d = st_acc || rd_done;
    rsp_data_d  = rd_done ? dn_rd_data : {{(DW-CNT_W){1'b0}}, cnt_q};
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rd_pend_q   <= 1'b0;
      rsp_valid_q <= 1'b0;
    end else begin
      rd_pend_q   <= rd_pend_d;
      rsp_valid_q <= rsp_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_acc)      rd_addr_q  <= cpu_req_addr;
    if (rsp_valid_d) rsp_data_q <= rsp_data_d;
  end

  assign cpu_rsp_valid = rsp_valid_q;
  assign cpu_rsp_rdata = rsp_data_q;

endmodule

// File: rtl/pwb_bridge_chk.sv
module pwb_bridge_chk #(
  parameter int          AW          = 32,
  parameter int          DW          = 32,
  parameter int          DEPTH       = 8,
  parameter logic [31:0] STATUS_ADDR = 32'hFFFF_FFF0,
  parameter int          CNT_W       = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_req_valid,
  input logic             cpu_req_ready,
  input logic             cpu_req_write,
  input logic [AW-1:0]    cpu_req_addr,
  input logic             cpu_rsp_valid,
  input logic [DW-1:0]    cpu_rsp_rdata,
  input logic             dn_req_valid,
  input logic             dn_req_ready,
  input logic             dn_req_write,
  input logic [AW-1:0]    dn_req_addr,
  input logic             dn_rd_valid,
  input logic [DW-1:0]    dn_rd_data,
  input logic [CNT_W-1:0] out_cnt,
  input logic [CNT_W-1:0] buf_level,
  input logic             rd_pend
);

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_write && !rd_pend && (buf_level < CNT_W'(DEPTH)))
      |-> cpu_req_ready)
    else $error("p_accept_r1");

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_level == CNT_W'(DEPTH)) |-> !(cpu_req_ready && cpu_req_write))
    else $error("p_no_overflow_r2");

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid && !dn_req_ready)
      |=> (dn_req_valid && $stable(dn_req_addr) && $stable(dn_req_write)))
    else $error("p_req_hold_r3");

  p_fence_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid && !dn_req_write) |-> (out_cnt == '0))
    else $error("p_fence_r6");

  p_rd_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_rd_valid && rd_pend)
      |=> (cpu_rsp_valid && (cpu_rsp_rdata == $past(dn_rd_data))))
    else $error("p_rd_return_r7");

  p_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready && !cpu_req_write
       && (cpu_req_addr == AW'(STATUS_ADDR)))
      |=> (cpu_rsp_valid && (cpu_rsp_rdata == DW'($past(out_cnt)))))
    else $error("p_status_r8");

  p_cnt_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt == buf_level)
    else $error("p_cnt_match_r9");

  p_rd_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |-> !cpu_req_ready)
    else $error("p_rd_block_r10");

  p_reset_clear_r11: assert property (@(posedge clk)
    !rst_n |=> ((out_cnt == '0) && (buf_level == '0) && !rd_pend && !dn_req_valid))
    else $error("p_reset_clear_r11");

endmodule

bind pwb_bridge pwb_bridge_chk #(
  .AW(AW), .DW(DW), .DEPTH(DEPTH), .STATUS_ADDR(STATUS_ADDR), .CNT_W(CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_sn),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_ready (cpu_req_ready),
  .cpu_req_write (cpu_req_write),
  .cpu_req_addr  (cpu_req_addr),
  .cpu_rsp_valid (cpu_rsp_valid),
  .cpu_rsp_rdata (cpu_rsp_rdata),
  .dn_req_valid  (dn_req_valid),
  .dn_req_ready  (dn_req_ready),
  .dn_req_write  (dn_req_write),
  .dn_req_addr   (dn_req_addr),
  .dn_rd_valid   (dn_rd_valid),
  .dn_rd_data    (dn_rd_data),
  .out_cnt       (cnt_q),
  .buf_level     (buf_level),
  .rd_pend       (rd_pend_q)
);

// File: tb/sim_pwb_bridge.sv
module sim_pwb_bridge;

  localparam int          CLK_PERIOD = 10;
  localparam int          AW         = 32;
  localparam int          DW         = 32;
  localparam int          DEPTH      = 8;
  localparam logic [31:0] STAT       = 32'hFFFF_FFF0;
  localparam logic [31:0] RMASK      = 32'hA5A5_0000;

  logic          clk, rst_n;
  logic          cpu_req_valid, cpu_req_ready, cpu_req_write;
  logic [AW-1:0] cpu_req_addr;
  logic [DW-1:0] cpu_req_wdata;
  logic          cpu_rsp_valid;
  logic [DW-1:0] cpu_rsp_rdata;
  logic          dn_req_valid, dn_req_ready, dn_req_write;
  logic [AW-1:0] dn_req_addr;
  logic [DW-1:0] dn_req_wdata;
  logic          dn_wr_ack, dn_wr_nack, dn_rd_valid;
  logic [DW-1:0] dn_rd_data;

  int total, bad;

  pwb_bridge #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .STATUS_ADDR(STAT)) u0 (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // downstream model state and logs
  bit            dn_stall;
  int            nack_left;
  int            pend;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_data;
  logic [AW-1:0] try_addr [64];
  logic [AW-1:0] acc_addr [64];
  logic [DW-1:0] acc_data [64];
  int            try_n, acc_n, rd_n, seq, last_ack_seq, rd_seq;

  always @(negedge clk) begin
    dn_wr_ack   = 1'b0;
    dn_wr_nack  = 1'b0;
    dn_rd_valid = 1'b0;
    if (!rst_n) begin
      pend         = 0;
      dn_req_ready = 1'b0;
    end else if (pend == 1) begin
      dn_req_ready = 1'b0;
      if (nack_left > 0) begin
        dn_wr_nack = 1'b1;
        nack_left--;
      end else begin
        dn_wr_ack = 1'b1;
        acc_addr[acc_n % 64] = p_addr;
        acc_data[acc_n % 64] = p_data;
        acc_n++;
        last_ack_seq = seq;
        seq++;
      end
      pend = 0;
    end else if (pend == 2) begin
      dn_req_ready = 1'b0;
      dn_rd_valid  = 1'b1;
      dn_rd_data   = p_addr ^ RMASK;
      pend = 0;
    end else begin
      dn_req_ready = !dn_stall;
      if (dn_req_valid && dn_req_ready) begin
        p_addr = dn_req_addr;
        p_data = dn_req_wdata;
        if (dn_req_write) begin
          try_addr[try_n % 64] = dn_req_addr;
          try_n++;
          pend = 1;
        end else begin
          rd_seq = seq;
          seq++;
          rd_n++;
          pend = 2;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [31:0] a, input logic [31:0] d, output int waited);
    waited = 0;
    @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_write = 1'b1;
    cpu_req_addr  = a;
    cpu_req_wdata = d;
    #1;
    while (!cpu_req_ready) begin
      @(negedge clk);
      #1;
      waited++;
    end
    @(posedge clk);
    #1;
    cpu_req_valid = 1'b0;
    cpu_req_write = 1'b0;
  endtask

  task automatic cpu_read(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_write = 1'b0;
    cpu_req_addr  = a;
    #1;
    while (!cpu_req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    cpu_req_valid = 1'b0;
    while (!cpu_rsp_valid) @(negedge clk);
    d = cpu_rsp_rdata;
  endtask

  task automatic drain();
    logic [31:0] s;
    s = 32'hFFFF;
    for (int k = 0; k < 200 && s != 0; k++) cpu_read(STAT, s);
    check(s == 0, "R9", "count after drain", s, 0);
  endtask

  task automatic t_reset();
    logic [31:0] s;
    check(cpu_rsp_valid == 1'b0, "R11", "rsp_valid after reset", 32'(cpu_rsp_valid), 0);
    check(dn_req_valid == 1'b0, "R11", "dn_req_valid after reset", 32'(dn_req_valid), 0);
    cpu_read(STAT, s);
    check(s == 0, "R8", "status after reset", s, 0);
  endtask

  task automatic t_posted();
    int w, base, rbase;
    logic [31:0] s;
    dn_stall = 1'b1;
    base  = acc_n;
    rbase = rd_n;
    for (int i = 0; i < 3; i++) begin
      cpu_write(32'h100 + 32'(i * 4), 32'hD000 + 32'(i), w);
      check(w == 0, "R1", "posted write wait cycles", 32'(w), 0);
    end
    cpu_read(STAT, s);
    check(s == 3, "R8", "status with 3 buffered", s, 3);
    check(rd_n == rbase, "R8", "status read sent downstream", 32'(rd_n - rbase), 0);
    dn_stall = 1'b0;
    drain();
    check(acc_n - base == 3, "R5", "acked writes", 32'(acc_n - base), 3);
    for (int i = 0; i < 3; i++)
      check(acc_addr[(base + i) % 64] == 32'h100 + 32'(i * 4), "R5", "ack order addr",
            acc_addr[(base + i) % 64], 32'h100 + 32'(i * 4));
  endtask

  task automatic t_full();
    int w, base;
    logic [31:0] s;
    dn_stall = 1'b1;
    base = acc_n;
    for (int i = 0; i < DEPTH; i++) cpu_write(32'h200 + 32'(i * 4), 32'hE000 + 32'(i), w);
    cpu_read(STAT, s);
    check(s == DEPTH, "R9", "status when full", s, DEPTH);
    @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_write = 1'b1;
    cpu_req_addr  = 32'h2F0;
    cpu_req_wdata = 32'hEEEE;
    for (int k = 0; k < 4; k++) begin
      #1;
      check(cpu_req_ready == 1'b0, "R2", "ready while full", 32'(cpu_req_ready), 0);
      @(negedge clk);
    end
    cpu_req_valid = 1'b0;
    cpu_req_write = 1'b0;
    dn_stall = 1'b0;
    cpu_write(32'h2F0, 32'hEEEE, w);
    drain();
    check(acc_n - base == DEPTH + 1, "R2", "writes after full", 32'(acc_n - base), DEPTH + 1);
    check(acc_addr[(base + DEPTH) % 64] == 32'h2F0, "R5", "last write addr",
          acc_addr[(base + DEPTH) % 64], 32'h2F0);
    check(acc_data[(base + DEPTH) % 64] == 32'hEEEE, "R5", "last write data",
          acc_data[(base + DEPTH) % 64], 32'hEEEE);
  endtask

  task automatic t_nack();
    int w, tb0, ab0;
    tb0 = try_n;
    ab0 = acc_n;
    dn_stall  = 1'b0;
    nack_left = 2;
    cpu_write(32'h300, 32'hA1, w);
    cpu_write(32'h304, 32'hA2, w);
    drain();
    check(try_n - tb0 == 4, "R4", "downstream attempts", 32'(try_n - tb0), 4);
    for (int i = 0; i < 3; i++)
      check(try_addr[(tb0 + i) % 64] == 32'h300, "R4", "resent addr",
            try_addr[(tb0 + i) % 64], 32'h300);
    check(try_addr[(tb0 + 3) % 64] == 32'h304, "R4", "next addr",
          try_addr[(tb0 + 3) % 64], 32'h304);
    check(acc_n - ab0 == 2, "R4", "acked after nacks", 32'(acc_n - ab0), 2);
    check(acc_data[ab0 % 64] == 32'hA1, "R5", "first ack data", acc_data[ab0 % 64], 32'hA1);
  endtask

  task automatic t_fence();
    int w, ab0, rb0;
    logic [31:0] d;
    dn_stall = 1'b1;
    ab0 = acc_n;
    rb0 = rd_n;
    cpu_write(32'h400, 32'hB1, w);
    cpu_write(32'h404, 32'hB2, w);
    fork
      cpu_read(32'h480, d);
      begin
        repeat (4) @(negedge clk);
        #2;
        cpu_req_valid = 1'b1;
        cpu_req_write = 1'b1;
        cpu_req_addr  = 32'h4F0;
        #1;
        check(cpu_req_ready == 1'b0, "R10", "ready while read pending", 32'(cpu_req_ready), 0);
        cpu_req_valid = 1'b0;
        cpu_req_write = 1'b0;
        repeat (2) @(negedge clk);
        dn_stall = 1'b0;
      end
    join
    check(d == (32'h480 ^ RMASK), "R7", "read data", d, 32'h480 ^ RMASK);
    check(rd_n - rb0 == 1, "R6", "reads forwarded", 32'(rd_n - rb0), 1);
    check(acc_n - ab0 == 2, "R6", "writes acked before read", 32'(acc_n - ab0), 2);
    check(rd_seq > last_ack_seq, "R6", "read after last ack", 32'(rd_seq), 32'(last_ack_seq + 1));
    drain();
    check(acc_n - ab0 == 2, "R10", "refused write not sent", 32'(acc_n - ab0), 2);
  endtask

  task automatic t_stream();
    int w, ab0;
    dn_stall = 1'b0;
    ab0 = acc_n;
    for (int i = 0; i < 6; i++) cpu_write(32'h500 + 32'(i * 4), 32'hC0 + 32'(i), w);
    drain();
    check(acc_n - ab0 == 6, "R9", "stream acked", 32'(acc_n - ab0), 6);
    for (int i = 0; i < 6; i++)
      check(acc_data[(ab0 + i) % 64] == 32'hC0 + 32'(i), "R5", "stream order",
            acc_data[(ab0 + i) % 64], 32'hC0 + 32'(i));
  endtask

  task automatic t_midreset();
    int w, ab0;
    logic [31:0] s;
    dn_stall = 1'b1;
    for (int i = 0; i < 3; i++) cpu_write(32'h600 + 32'(i * 4), 32'hF0 + 32'(i), w);
    ab0 = acc_n;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(dn_req_valid == 1'b0, "R11", "dn_req_valid after reset", 32'(dn_req_valid), 0);
    cpu_read(STAT, s);
    check(s == 0, "R11", "count after reset", s, 0);
    dn_stall = 1'b0;
    repeat (10) @(negedge clk);
    check(acc_n == ab0, "R11", "discarded writes sent", 32'(acc_n - ab0), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    try_n = 0; acc_n = 0; rd_n = 0; seq = 0; last_ack_seq = -1; rd_seq = 0;
    pend = 0; nack_left = 0; dn_stall = 1'b0;
    dn_req_ready = 1'b0; dn_wr_ack = 1'b0; dn_wr_nack = 1'b0;
    dn_rd_valid = 1'b0; dn_rd_data = '0;
    cpu_req_valid = 1'b0; cpu_req_write = 1'b0; cpu_req_addr = '0; cpu_req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_posted();
    t_full();
    t_nack();
    t_fence();
    t_stream();
    t_midreset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule